// File: doc/BRIEF.md
# Full-Duplex SPI Master with Independent Byte Counts

This block is a serial peripheral interface master that runs one transaction for each start pulse. Each transaction has two byte counts, one for the outgoing side and one for the incoming side, and the two counts may differ. The transaction lasts for the larger of the two counts. Outgoing bytes are pulled from a valid/ready byte port that stands in for a transmit buffer. Once that count is used up, the value of a static fill byte is sent instead. Incoming bytes are pushed out as one-cycle strobes. Bytes captured past the receive count are dropped.

The block drives the serial clock, the data-out line and an active-low select, and it samples the data-in line. It raises three completion pulses: one for the transmit side, one for the receive side, and one for the whole transfer. A stop request ends the transaction early and forces out any side pulse that has not yet been given. The clock divider, clock polarity, clock phase and bit order are static configuration inputs. The default use is polarity 0 with sampling on the trailing edge, most significant bit first.

Top module: `spi_split_master`

## Requirements
- R1: A start pulse is accepted only while the block is idle. `started` is high for exactly one cycle, in the cycle after the edge that accepted the start. A start that arrives during a transaction has no effect.
- R2: The two byte counts are captured when a start is accepted. Changing `tx_count` or `rx_count` after `started` does not alter the running transaction.
- R3: While `cs_n` is high, `sck` rests at `cpol`. During a byte, `sck` toggles every `clk_div`+1 clock cycles, so its period is 2×(`clk_div`+1) cycles.
- R4: With `cpha`=1, data-in is sampled on the trailing clock edge and data-out changes on the leading edge. With `cpha`=0, data-in is sampled on the leading edge and data-out changes on the trailing edge. With `lsb_first`=0 bit 7 goes first; with `lsb_first`=1 bit 0 goes first. The same bit order applies in both directions.
- R5: A transaction shifts exactly max(`tx_count`,`rx_count`) bytes. Each byte shifted out is matched by one byte shifted in during the same eight clock periods.
- R6: `tx_done` pulses once per transaction, right after the last counted outgoing byte has been shifted out.
- R7: `rx_done` pulses once per transaction, in the same cycle as the `rx_valid` strobe of the last counted incoming byte. Bytes beyond `rx_count` produce no `rx_valid`.
- R8: `tx_ready` is offered only for the first `tx_count` bytes. Every later byte sent is `fill_byte`.
- R9: `xfer_done` pulses once, only after both `tx_done` and `rx_done` have been issued for the current transaction. It comes one cycle after `cs_n` returns high. When both counts are zero, no byte is shifted, and `tx_done`, `rx_done` and `xfer_done` are still each issued once.
- R10: A `stop` during a transaction does the following: it raises `cs_n`, returns `sck` to `cpol`, and issues in the next cycle any `tx_done` or `rx_done` not yet given. One cycle after that, it pulses `stopped`. In this case no `xfer_done` is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | DIV_W | Half-period length of `sck`, minus one |
| cpol | input | 1 | Idle level of `sck` |
| cpha | input | 1 | 1: sample on trailing edge; 0: sample on leading edge |
| lsb_first | input | 1 | 1: least significant bit first |
| start | input | 1 | Begin a transaction |
| stop | input | 1 | End the running transaction early |
| tx_count | input | CNT_W | Number of bytes taken from the transmit port |
| rx_count | input | CNT_W | Number of received bytes delivered |
| fill_byte | input | 8 | Byte sent once the transmit count is exhausted |
| tx_data | input | 8 | Transmit byte |
| tx_valid | input | 1 | Transmit byte available |
| tx_ready | output | 1 | Block takes `tx_data` at this edge if `tx_valid` |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low select |
| miso | input | 1 | Serial data in |
| started | output | 1 | Transaction accepted pulse |
| tx_done | output | 1 | Transmit side finished pulse |
| rx_done | output | 1 | Receive side finished pulse |
| xfer_done | output | 1 | Whole transaction finished pulse |
| stopped | output | 1 | Early stop finished pulse |

## Verification
The assertions assume that `cpol`, `cpha`, `lsb_first` and `clk_div` change only while `cs_n` is high. The idle-clock check allows one cycle for `sck` to follow a new `cpol`. They also assume that `start` and `stop` are single-cycle pulses. The bench changes the configuration only between transactions. It drives `start` and `stop` for exactly one cycle each and keeps `tx_valid` high, so a transmit request never stalls a byte. The serial slave model in the bench follows the configured phase and bit order and takes no part in timing decisions.

// File: rtl/spi_split_master.sv
module spi_split_master #(
  parameter int CNT_W = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             lsb_first,
  input  logic             start,
  input  logic             stop,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [7:0]       fill_byte,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             sck,
  output logic             mosi,
  output logic             cs_n,
  input  logic             miso,
  output logic             started,
  output logic             tx_done,
  output logic             rx_done,
  output logic             xfer_done,
  output logic             stopped
);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_SHIFT, S_FIN, S_END, S_HALT} state_t;

  state_t           st;
  logic [CNT_W-1:0] tx_n, rx_n, idx;
  logic [DIV_W-1:0] dcnt;
  logic [3:0]       hc;
  logic [7:0]       tx_sh, rx_sh;
  logic             tx_fl, rx_fl;

  wire [CNT_W-1:0] total   = (tx_n > rx_n) ? tx_n : rx_n;
  wire [CNT_W-1:0] idx_nx  = idx + 1'b1;
  wire             tick    = (dcnt == clk_div);
  wire             smp_now = cpha ? hc[0] : ~hc[0];
  wire             chg_now = (cpha ? ~hc[0] : hc[0]) && (hc != 4'd0) && (hc != 4'd15);
  wire [7:0]       rx_nx   = lsb_first ? {miso, rx_sh[7:1]} : {rx_sh[6:0], miso};
  wire [7:0]       tx_nx   = lsb_first ? {1'b0, tx_sh[7:1]} : {tx_sh[6:0], 1'b0};
  wire             active  = (st == S_LOAD) || (st == S_SHIFT);

  assign mosi     = lsb_first ? tx_sh[0] : tx_sh[7];
  assign tx_ready = (st == S_LOAD) && (idx < tx_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  tx_n <= '0;  rx_n <= '0;  idx <= '0;
      dcnt <= '0;    hc <= '0;    tx_sh <= '0; rx_sh <= '0;
      tx_fl <= 1'b0; rx_fl <= 1'b0;
      sck <= 1'b0;   cs_n <= 1'b1; rx_data <= '0; rx_valid <= 1'b0;
      started <= 1'b0; tx_done <= 1'b0; rx_done <= 1'b0;
      xfer_done <= 1'b0; stopped <= 1'b0;
    end else begin
      started <= 1'b0; tx_done <= 1'b0; rx_done <= 1'b0;
      xfer_done <= 1'b0; stopped <= 1'b0; rx_valid <= 1'b0;
      if (active && stop) begin
        st <= S_HALT;  sck <= cpol;  cs_n <= 1'b1;
        tx_done <= ~tx_fl;  rx_done <= ~rx_fl;
        tx_fl <= 1'b1;  rx_fl <= 1'b1;
      end else begin
        case (st)
          S_IDLE: begin
            sck <= cpol;
            if (start) begin
              tx_n <= tx_count;  rx_n <= rx_count;  idx <= '0;
              tx_fl <= 1'b0;  rx_fl <= 1'b0;
              cs_n <= 1'b0;  started <= 1'b1;  st <= S_LOAD;
            end
          end
          S_LOAD: begin
            dcnt <= '0;  hc <= '0;
            if (idx == total) st <= S_FIN;
            else if (idx < tx_n) begin
              if (tx_valid) begin tx_sh <= tx_data; st <= S_SHIFT; end
            end else begin
              tx_sh <= fill_byte;  st <= S_SHIFT;
            end
          end
          S_SHIFT: begin
            if (!tick) dcnt <= dcnt + 1'b1;
            else begin
              dcnt <= '0;  sck <= ~sck;  hc <= hc + 4'd1;
              if (smp_now) rx_sh <= rx_nx;
              if (chg_now) tx_sh <= tx_nx;
              if (hc == 4'd15) begin
                idx <= idx_nx;  st <= S_LOAD;
                if (idx < rx_n) begin
                  rx_valid <= 1'b1;
                  rx_data  <= cpha ? rx_nx : rx_sh;
                end
                if (idx_nx == tx_n) begin tx_done <= 1'b1; tx_fl <= 1'b1; end
                if (idx_nx == rx_n) begin rx_done <= 1'b1; rx_fl <= 1'b1; end
              end
            end
          end
          S_FIN: begin
            cs_n <= 1'b1;  tx_done <= ~tx_fl;  rx_done <= ~rx_fl;
            tx_fl <= 1'b1;  rx_fl <= 1'b1;  st <= S_END;
          end
          S_END: begin
            xfer_done <= 1'b1;  st <= S_IDLE;
          end
          default: begin
            stopped <= 1'b1;  st <= S_IDLE;
          end
        endcase
      end
    end
  end

  // R1
  started_chk: assert property (@(posedge clk) disable iff (!rst_n) started |-> $past(start));
  // R3
  idle_sck_chk: assert property (@(posedge clk) disable iff (!rst_n) (cs_n && $stable(cpol)) |-> (sck == cpol));
  // R6
  tx_once_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_done |-> !$past(tx_fl));
  // R7
  rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |-> !$past(rx_fl));
  // R8
  txreq_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_ready |-> !cs_n);
  // R9
  end_both_chk: assert property (@(posedge clk) disable iff (!rst_n) xfer_done |-> (tx_fl && rx_fl && cs_n));
  // R10
  stop_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) stopped |-> (cs_n && !xfer_done));

endmodule

// File: tb/spi_split_master_tb.sv
module spi_split_master_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] clk_div = 8'd1;
  logic cpol = 1'b0, cpha = 1'b1, lsb_first = 1'b0;
  logic start = 1'b0, stop = 1'b0;
  logic [7:0] tx_count = '0, rx_count = '0, fill_byte = 8'hC3;
  logic [7:0] tx_data;
  logic tx_valid = 1'b1;
  logic tx_ready, rx_valid, sck, mosi, cs_n, miso;
  logic [7:0] rx_data;
  logic started, tx_done, rx_done, xfer_done, stopped;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  spi_split_master dut_i (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .cpol(cpol), .cpha(cpha),
    .lsb_first(lsb_first), .start(start), .stop(stop), .tx_count(tx_count),
    .rx_count(rx_count), .fill_byte(fill_byte), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .sck(sck), .mosi(mosi), .cs_n(cs_n), .miso(miso),
    .started(started), .tx_done(tx_done), .rx_done(rx_done),
    .xfer_done(xfer_done), .stopped(stopped));

  function automatic logic [7:0] tbyte(int k);
    return 8'((k * 37) ^ 8'hC1);
  endfunction
  function automatic logic [7:0] sbyte(int k);
    return 8'(8'h5A + k * 19);
  endfunction
  function automatic logic obit(int n, logic lsb);
    logic [7:0] b;
    b = sbyte(n / 8);
    return lsb ? b[n % 8] : b[7 - (n % 8)];
  endfunction

  int tidx = 0;
  assign tx_data = tbyte(tidx);
  always @(posedge clk) if (tx_ready && tx_valid) tidx <= tidx + 1;

  int s_bits = 0, s_ocnt = 0;
  logic [7:0] s_in = '0;
  logic [7:0] mos [0:15];
  logic s_miso = 1'b0;
  assign miso = s_miso;

  always @(negedge cs_n) begin
    s_bits = 0; s_ocnt = 0;
    if (!cpha) begin s_miso = obit(0, lsb_first); s_ocnt = 1; end
  end

  always @(sck) begin
    if (!cs_n) begin
      if ((sck != cpol) == cpha) begin
        s_miso = obit(s_ocnt, lsb_first); s_ocnt++;
      end else begin
        if (lsb_first) s_in[s_bits % 8] = mosi; else s_in[7 - (s_bits % 8)] = mosi;
        s_bits++;
        if (s_bits % 8 == 0 && s_bits / 8 <= 16) mos[s_bits / 8 - 1] = s_in;
      end
    end
  end

  int cyc = 0, n_start = 0, n_txd = 0, n_rxd = 0, n_end = 0, n_stop = 0, n_rx = 0;
  int txd_bits = 0, rxd_bits = 0, txd_cyc = 0, stop_cyc = 0, last_rise = 0, per = 0;
  logic [7:0] rxb [0:63];
  logic sck_q = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (started) n_start++;
    if (tx_done) begin n_txd++; txd_bits = s_bits; txd_cyc = cyc; end
    if (rx_done) begin n_rxd++; rxd_bits = s_bits; end
    if (xfer_done) n_end++;
    if (stopped) begin n_stop++; stop_cyc = cyc; end
    if (rx_valid) begin rxb[n_rx % 64] = rx_data; n_rx++; end
    if (sck && !sck_q && !cs_n) begin per = cyc - last_rise; last_rise = cyc; end
    sck_q = sck;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic kick();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_finish();
    int e0, s0;
    e0 = n_end; s0 = n_stop;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (n_end != e0 || n_stop != s0) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic run_xfer(input int ntx, input int nrx, input string req);
    int b_start, b_txd, b_rxd, b_end, b_stop, b_rx, b_t, total;
    b_start = n_start; b_txd = n_txd; b_rxd = n_rxd; b_end = n_end;
    b_stop = n_stop; b_rx = n_rx; b_t = tidx;
    total = (ntx > nrx) ? ntx : nrx;
    tx_count = 8'(ntx); rx_count = 8'(nrx);
    kick();
    chk(started == 1'b1, {req, " R1 started next cycle"}, int'(started), 1);
    wait_finish();
    chk(s_bits == 8 * total, {req, " R5 bits shifted"}, s_bits, 8 * total);
    chk(n_rx - b_rx == nrx, {req, " R7 rx strobes"}, n_rx - b_rx, nrx);
    chk(tidx - b_t == ntx, {req, " R8 tx handshakes"}, tidx - b_t, ntx);
    chk(n_txd - b_txd == 1 && n_rxd - b_rxd == 1, {req, " R6 R7 one done each"},
        (n_txd - b_txd) * 10 + n_rxd - b_rxd, 11);
    chk(n_end - b_end == 1 && n_stop == b_stop, {req, " R9 end once"}, n_end - b_end, 1);
    chk(n_start - b_start == 1, {req, " R1 single start"}, n_start - b_start, 1);
    if (total > 0) begin
      chk(txd_bits == 8 * ntx, {req, " R6 tx_done position"}, txd_bits, 8 * ntx);
      chk(rxd_bits == 8 * nrx, {req, " R7 rx_done position"}, rxd_bits, 8 * nrx);
    end
    for (int k = 0; k < total && k < 16; k++) begin
      logic [7:0] e;
      e = (k < ntx) ? tbyte(b_t + k) : fill_byte;
      chk(mos[k] == e, {req, " R4 R8 byte out"}, int'(mos[k]), int'(e));
    end
    for (int k = 0; k < nrx; k++)
      chk(rxb[(b_rx + k) % 64] == sbyte(k), {req, " R4 R5 byte in"},
          int'(rxb[(b_rx + k) % 64]), int'(sbyte(k)));
    chk(cs_n == 1'b1 && sck == cpol, {req, " R3 idle lines"}, int'({cs_n, sck}), int'({1'b1, cpol}));
  endtask

  task automatic t_reset();
    chk(cs_n == 1'b1, "R3 reset cs_n", int'(cs_n), 1);
    chk(sck == 1'b0, "R3 reset sck", int'(sck), 0);
    chk(!tx_ready && !rx_valid && !started && !xfer_done, "R1 reset quiet",
        int'({tx_ready, rx_valid, started, xfer_done}), 0);
  endtask

  task automatic t_busy_and_buffer();
    int b_start, b_t;
    b_start = n_start; b_t = tidx;
    tx_count = 8'd2; rx_count = 8'd2;
    kick();
    tx_count = 8'd5; rx_count = 8'd1;
    repeat (6) @(negedge clk);
    kick();
    wait_finish();
    chk(n_start - b_start == 1, "R1 start while busy ignored", n_start - b_start, 1);
    chk(s_bits == 16, "R2 counts held after started", s_bits, 16);
    chk(tidx - b_t == 2, "R2 tx handshakes from captured count", tidx - b_t, 2);
  endtask

  task automatic t_stop();
    int b_txd, b_rxd, b_end, b_stop;
    b_txd = n_txd; b_rxd = n_rxd; b_end = n_end; b_stop = n_stop;
    clk_div = 8'd3;
    tx_count = 8'd6; rx_count = 8'd6;
    kick();
    for (int i = 0; i < 5000 && s_bits < 12; i++) @(negedge clk);
    stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    chk(cs_n == 1'b1 && sck == cpol, "R10 lines released at stop", int'({cs_n, sck}), 2);
    wait_finish();
    chk(n_stop - b_stop == 1, "R10 stopped once", n_stop - b_stop, 1);
    chk(n_txd - b_txd == 1 && n_rxd - b_rxd == 1, "R10 forced dones",
        (n_txd - b_txd) * 10 + n_rxd - b_rxd, 11);
    chk(stop_cyc - txd_cyc == 1, "R10 stopped after dones", stop_cyc - txd_cyc, 1);
    chk(n_end == b_end, "R10 no xfer_done", n_end - b_end, 0);
    chk(s_bits < 48, "R10 transfer cut short", s_bits, 47);
    clk_div = 8'd1;
  endtask

  task automatic t_period();
    clk_div = 8'd2;
    run_xfer(1, 1, "period");
    chk(per == 6, "R3 sck period", per, 6);
    clk_div = 8'd1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_xfer(3, 3, "equal mode1");
    run_xfer(4, 2, "tx longer");
    run_xfer(1, 3, "rx longer");
    run_xfer(0, 0, "zero counts");
    t_busy_and_buffer();
    t_stop();
    t_period();
    cpha = 1'b0; lsb_first = 1'b1;
    repeat (2) @(negedge clk);
    run_xfer(2, 2, "mode0 lsb");
    cpol = 1'b1; cpha = 1'b1; lsb_first = 1'b0;
    repeat (2) @(negedge clk);
    run_xfer(2, 3, "mode3 msb");
    cpha = 1'b0;
    repeat (2) @(negedge clk);
    run_xfer(3, 1, "mode2 msb");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule